// File: doc/BRIEF.md
# Socket Activity Indicator

This block drives an active-high indicator output that lights while a removable-card socket is busy. A qualified activity event loads a hold counter with a fixed number of millisecond ticks. The indicator stays on while the counter is non-zero. Each further event reloads the full period, so traffic that repeats at least once per period keeps the indicator lit without a gap. A built-in prescaler turns the system clock into the millisecond tick. It restarts on every reload, so the lit time after the last event is exact to the cycle.

Activity is qualified by the socket state: a card must be present and powered, and it must not be held in reset. For a 16-bit card, the activity source is an active-low ready/interrupt line. For a 32-bit bus card, the sources are the frame, initiator-ready and card-request strobes. All four strobes pass through a two-flop synchroniser before use.

Several power-management conditions turn the indicator off and clear the counter at once: system suspend, a pending bus-clock stop, and the low-power device states D1 and D2. These conditions cut the indicator so that it never appears stuck while the clock is stopped.

Top module: `act_led_top`

## Requirements
- R1: `led_on` is high only while the hold counter is non-zero. It is low after the synchronous reset `rst` and low whenever the counter is empty.
- R2: The indicator rises 3 clock cycles after the cycle in which a one-cycle activity strobe is applied (two synchroniser stages, then the counter load). It then stays high for exactly HOLD_TICKS × TICK_CYCLES cycles.
- R3: An event while the counter is running reloads the full period, and the prescaler restarts with it. Events spaced HOLD_TICKS × TICK_CYCLES cycles apart or closer keep `led_on` high without a gap. One cycle more leaves a gap of one low cycle.
- R4: An event counts only when `sock_present`=1, `sock_powered`=1 and `sock_in_reset`=0. In every other combination the strobes leave `led_on` low.
- R5: With `card_wide`=0 (16-bit card), activity is `rdy_irq_n`=0. The wide-card strobes have no effect.
- R6: With `card_wide`=1 (32-bit bus card), activity is any of `wide_frame`, `wide_irdy` or `wide_req` at 1. `rdy_irq_n` has no effect.
- R7: `sys_suspend`=1, `clk_stop_pend`=1, or `dev_pstate` equal to 1 (D1) or 2 (D2) clears the counter, and `led_on` is low from the next cycle. A forcing condition wins over an event in the same cycle.
- R8: `dev_pstate` equal to 0 (D0) or 3 (D3) does not force the indicator off.
- R9: After a forcing condition clears, `led_on` stays low until a new qualified event occurs. An event that is still active re-lights the indicator on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sock_present | input | 1 | Card inserted |
| sock_powered | input | 1 | Card supply on |
| sock_in_reset | input | 1 | Card held in reset |
| card_wide | input | 1 | 1 = 32-bit bus card, 0 = 16-bit card |
| rdy_irq_n | input | 1 | 16-bit card ready/interrupt line, active low |
| wide_frame | input | 1 | 32-bit card frame strobe, active high |
| wide_irdy | input | 1 | 32-bit card initiator-ready strobe, active high |
| wide_req | input | 1 | 32-bit card request strobe, active high |
| sys_suspend | input | 1 | System suspend |
| clk_stop_pend | input | 1 | Bus clock about to stop |
| dev_pstate | input | 2 | Device power state, 0..3 = D0..D3 |
| led_on | output | 1 | Activity indicator, active high |

## Verification
Two pairs of functions can act on the counter in the same cycle.

The first pair is a reload and the final tick decrement. The bench provokes it by spacing two events exactly one period apart. It judges the result by the lit time over a window, which must be one continuous stretch of period plus spacing. A spacing one cycle longer must show two separate stretches.

The second pair is a forcing condition and a live event. The bench provokes it by holding a frame strobe high while asserting suspend. The indicator must go low on the next cycle and stay low while suspend is asserted. It must come back one cycle after suspend is released, because the event is still active.

// File: rtl/act_led_pkg.sv
package act_led_pkg;

    typedef enum logic [1:0] {
        PS_D0 = 2'd0,
        PS_D1 = 2'd1,
        PS_D2 = 2'd2,
        PS_D3 = 2'd3
    } pstate_e;

    typedef struct packed {
        logic rdy_n;
        logic frame;
        logic irdy;
        logic req;
    } strobe_t;

    typedef struct packed {
        logic present;
        logic powered;
        logic in_reset;
        logic wide;
    } sock_t;

    localparam int STROBE_W = $bits(strobe_t);
    localparam strobe_t STROBE_IDLE = '{rdy_n: 1'b1, frame: 1'b0, irdy: 1'b0, req: 1'b0};

    function automatic logic pstate_blocks(pstate_e p);
        return (p == PS_D1) || (p == PS_D2);
    endfunction

    function automatic logic socket_ready(sock_t s);
        return s.present && s.powered && !s.in_reset;
    endfunction

endpackage

// File: rtl/act_led_sync.sv
module act_led_sync #(
    parameter int                 WIDTH = 4,
    parameter logic [WIDTH-1:0]   IDLE  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;
    logic [WIDTH-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= IDLE;
            stage2 <= IDLE;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/act_led_detect.sv
module act_led_detect
    import act_led_pkg::*;
(
    input  sock_t   sock,
    input  strobe_t strobes,
    output logic    evt
);
    logic wide_hit;
    logic narrow_hit;

    always_comb begin
        wide_hit   = strobes.frame || strobes.irdy || strobes.req;
        narrow_hit = !strobes.rdy_n;
        evt        = socket_ready(sock) && (sock.wide ? wide_hit : narrow_hit);
    end
endmodule

// File: rtl/act_led_tick.sv
module act_led_tick #(
    parameter int TICK_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    output logic tick
);
    generate
        if (TICK_CYCLES <= 1) begin : g_direct
            assign tick = 1'b1;
        end else begin : g_div
            localparam int PW = $clog2(TICK_CYCLES);
            localparam logic [PW-1:0] LAST = PW'(TICK_CYCLES - 1);
            logic [PW-1:0] pre;

            always_ff @(posedge clk) begin
                if (rst || restart || pre == LAST) begin
                    pre <= '0;
                end else begin
                    pre <= pre + 1'b1;
                end
            end

            assign tick = (pre == LAST);

            assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/act_led_hold.sv
module act_led_hold #(
    parameter int HOLD_TICKS = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic evt,
    input  logic force_off,
    input  logic tick,
    output logic active
);
    localparam int CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || force_off) begin
            cnt <= '0;
        end else if (evt) begin
            cnt <= FULL;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);

    assert_force_clears_R7: assert property (@(posedge clk) disable iff (rst)
        force_off |=> (cnt == '0));
    assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
        (evt && !force_off) |=> (cnt == FULL));
    assert_hold_steady_R2: assert property (@(posedge clk) disable iff (rst)
        (!evt && !force_off && !tick) |=> $stable(cnt));
    assert_range_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);
endmodule

// File: rtl/act_led_top.sv
module act_led_top
    import act_led_pkg::*;
#(
    parameter int TICK_CYCLES = 100000,
    parameter int HOLD_TICKS  = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sock_present,
    input  logic       sock_powered,
    input  logic       sock_in_reset,
    input  logic       card_wide,
    input  logic       rdy_irq_n,
    input  logic       wide_frame,
    input  logic       wide_irdy,
    input  logic       wide_req,
    input  logic       sys_suspend,
    input  logic       clk_stop_pend,
    input  logic [1:0] dev_pstate,
    output logic       led_on
);
    strobe_t raw_strobes;
    strobe_t sync_strobes;
    sock_t   sock;
    logic    evt;
    logic    force_off;
    logic    tick;
    logic    restart;

    always_comb begin
        raw_strobes = '{rdy_n: rdy_irq_n, frame: wide_frame, irdy: wide_irdy, req: wide_req};
        sock        = '{present: sock_present, powered: sock_powered,
                        in_reset: sock_in_reset, wide: card_wide};
        force_off   = sys_suspend || clk_stop_pend || pstate_blocks(pstate_e'(dev_pstate));
        restart     = evt || force_off || !led_on;
    end

    act_led_sync #(.WIDTH(STROBE_W), .IDLE(STROBE_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_strobes),
        .q   (sync_strobes)
    );

    act_led_detect u_detect (
        .sock    (sock),
        .strobes (sync_strobes),
        .evt     (evt)
    );

    act_led_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick)
    );

    act_led_hold #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .force_off (force_off),
        .tick      (tick),
        .active    (led_on)
    );

    assert_stay_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!led_on && !evt) |=> !led_on);
    assert_force_low_R7: assert property (@(posedge clk) disable iff (rst)
        force_off |=> !led_on);
endmodule

// File: tb/act_led_top_test.sv
module act_led_top_test;
    localparam int TICK = 4;
    localparam int HOLD = 3;
    localparam int PERIOD = TICK * HOLD;

    logic       clk = 1'b0;
    logic       rst;
    logic       sock_present, sock_powered, sock_in_reset, card_wide;
    logic       rdy_irq_n, wide_frame, wide_irdy, wide_req;
    logic       sys_suspend, clk_stop_pend;
    logic [1:0] dev_pstate;
    logic       led_on;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    act_led_top #(.TICK_CYCLES(TICK), .HOLD_TICKS(HOLD)) uut (
        .clk(clk), .rst(rst),
        .sock_present(sock_present), .sock_powered(sock_powered),
        .sock_in_reset(sock_in_reset), .card_wide(card_wide),
        .rdy_irq_n(rdy_irq_n), .wide_frame(wide_frame),
        .wide_irdy(wide_irdy), .wide_req(wide_req),
        .sys_suspend(sys_suspend), .clk_stop_pend(clk_stop_pend),
        .dev_pstate(dev_pstate), .led_on(led_on)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_strobe(input int s, input logic on);
        case (s)
            0: rdy_irq_n  = !on;
            1: wide_frame = on;
            2: wide_irdy  = on;
            default: wide_req = on;
        endcase
    endtask

    task automatic pulse(input int s);
        set_strobe(s, 1'b1);
        @(negedge clk);
        set_strobe(s, 1'b0);
    endtask

    task automatic window(input int n, output int hi, output int rises);
        logic prev;
        prev = led_on;
        hi = 0;
        rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (led_on) hi++;
            if (led_on && !prev) rises++;
            prev = led_on;
        end
    endtask

    task automatic retrig(input int g, output int hi, output int rises);
        logic prev;
        prev = 1'b0;
        hi = 0;
        rises = 0;
        set_strobe(1, 1'b1);
        @(negedge clk);
        set_strobe(1, 1'b0);
        for (int k = 2; k <= 60; k++) begin
            @(negedge clk);
            if (led_on) hi++;
            if (led_on && !prev) rises++;
            prev = led_on;
            if (k == g) set_strobe(1, 1'b1);
            if (k == g + 1) set_strobe(1, 1'b0);
        end
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hi, rises, expv;
        rst = 1'b1;
        sock_present = 1'b1; sock_powered = 1'b1; sock_in_reset = 1'b0; card_wide = 1'b0;
        rdy_irq_n = 1'b1; wide_frame = 1'b0; wide_irdy = 1'b0; wide_req = 1'b0;
        sys_suspend = 1'b0; clk_stop_pend = 1'b0; dev_pstate = 2'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset level", led_on, 0);
        window(10, hi, rises);
        check("R1 idle stays low", hi, 0);

        // R2: latency and exact lit time
        card_wide = 1'b0;
        pulse(0);
        @(negedge clk);
        check("R2 low at cycle 2", led_on, 0);
        @(negedge clk);
        check("R2 high at cycle 3", led_on, 1);
        hi = 0;
        while (led_on && hi < 100) begin
            hi++;
            @(negedge clk);
        end
        check("R2 lit length", hi, PERIOD);

        // R4 R5 R6: sweep of socket state, card type and strobe
        for (int st = 0; st < 8; st++) begin
            for (int w = 0; w < 2; w++) begin
                for (int s = 0; s < 4; s++) begin
                    sock_present  = st[0];
                    sock_powered  = st[1];
                    sock_in_reset = st[2];
                    card_wide     = w[0];
                    @(negedge clk);
                    pulse(s);
                    window(30, hi, rises);
                    expv = (st[0] && st[1] && !st[2] && ((w == 1) ? (s != 0) : (s == 0))) ? PERIOD : 0;
                    if (w == 1) check("R6 R4 wide card strobe sweep", hi, expv);
                    else        check("R5 R4 narrow card strobe sweep", hi, expv);
                end
            end
        end
        sock_present = 1'b1; sock_powered = 1'b1; sock_in_reset = 1'b0; card_wide = 1'b1;
        @(negedge clk);

        // R3: retrigger spacing
        retrig(2, hi, rises);
        check("R3 gap 2 lit", hi, PERIOD + 2);
        check("R3 gap 2 one stretch", rises, 1);
        retrig(5, hi, rises);
        check("R3 gap 5 lit", hi, PERIOD + 5);
        retrig(PERIOD, hi, rises);
        check("R3 gap equal period lit", hi, 2 * PERIOD);
        check("R3 gap equal period one stretch", rises, 1);
        retrig(PERIOD + 1, hi, rises);
        check("R3 gap past period lit", hi, 2 * PERIOD);
        check("R3 gap past period two stretches", rises, 2);

        // R7 R9: each forcing condition
        for (int f = 0; f < 4; f++) begin
            pulse(1);
            repeat (4) @(negedge clk);
            check("R7 lit before force", led_on, 1);
            case (f)
                0: sys_suspend = 1'b1;
                1: clk_stop_pend = 1'b1;
                2: dev_pstate = 2'd1;
                default: dev_pstate = 2'd2;
            endcase
            @(negedge clk);
            check("R7 forced low", led_on, 0);
            repeat (3) @(negedge clk);
            sys_suspend = 1'b0; clk_stop_pend = 1'b0; dev_pstate = 2'd0;
            window(20, hi, rises);
            check("R9 stays low after release", hi, 0);
        end

        // R8: D3 does not force
        dev_pstate = 2'd3;
        @(negedge clk);
        pulse(2);
        window(30, hi, rises);
        check("R8 D3 no force", hi, PERIOD);
        dev_pstate = 2'd0;

        // R7 R9: force against a live event
        wide_frame = 1'b1;
        repeat (6) @(negedge clk);
        check("R7 held strobe lit", led_on, 1);
        sys_suspend = 1'b1;
        @(negedge clk);
        check("R7 force beats event", led_on, 0);
        @(negedge clk);
        check("R7 force holds against event", led_on, 0);
        sys_suspend = 1'b0;
        @(negedge clk);
        check("R9 live event relights", led_on, 1);
        wide_frame = 1'b0;
        window(40, hi, rises);
        check("R2 lit after held strobe ends", hi, PERIOD + 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule